// File: doc/BRIEF.md
# Protected-Access Watchdog Timer

This block is an 8-bit watchdog timer for a small processor subsystem. A free-running prescaler divides the system clock. A 3-bit select field picks one of eight prescaler taps, and each pulse from that tap advances an 8-bit up-counter. When the counter wraps from 0xFF to 0x00, a sticky overflow flag is set. Depending on configuration, the overflow then raises a level interrupt request or a reset request that lasts a fixed number of cycles.

Software must rewrite the counter before it wraps. The counter and the control/status register can only be changed through a 16-bit word write whose upper byte is a key, so a stray byte store cannot stop the timer or reload the counter. A sticky flag can only be cleared by writing 0 to it, and only after software has read that flag as 1.

Top module: `pwdt_top`

## Requirements
- R1: After reset, address 0 (control/status) reads 0x18, address 1 (counter) reads 0x00, address 2 (reset control/status) reads 0x3F, and `irq` and `rst_req` are 0.
- R2: A word write (`bus_word`=1) to address 0 with key 0xA5 in `bus_wdata[15:8]` loads `bus_wdata[7:0]` into the control/status register. The same write with key 0x5A loads it into the counter. Any other key, and any byte write to address 0, changes neither register.
- R3: The counter advances only while control/status bit 5 (run) is 1. While run is 0, the counter is held at 0x00, and clearing run brings it to 0x00 within two cycles.
- R4: Control/status bits 2:0 select the count period: values 0 to 7 give 2, 32, 64, 128, 256, 512, 2048 and 4096 clock cycles per counter step.
- R5: A wrap of the counter from 0xFF to 0x00 sets control/status bit 7 (overflow flag).
- R6: A sticky flag (control/status bit 7, reset control/status bit 7) is cleared only by writing 0 to it after a read that showed it as 1. Writing 1 to it has no effect, and a wrap in the same cycle as the clear leaves the flag set.
- R7: Control/status bits 4:3 and reset control/status bits 5:0 always read 1, whatever is written to them.
- R8: `irq` equals control/status bit 7 AND control/status bit 6 (interrupt enable) AND NOT reset control/status bit 6 (reset enable).
- R9: With reset control/status bit 6 at 1, a counter wrap sets reset control/status bit 7 and holds `rst_req` high for exactly `RST_CYCLES` cycles.
- R10: The reset control/status register is written by a byte write (`bus_word`=0) to address 2. Only bits 6 and 7 are affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control/status, 1 counter, 2 reset control/status |
| bus_rd | input | 1 | Read strobe; arms the flag-clear mechanism |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = 16-bit keyed word write, 0 = byte write |
| bus_wdata | input | 16 | Write data; upper byte is the key on word writes |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Overflow interrupt request (level) |
| rst_req | output | 1 | Reset request pulse |

## Verification
Register writes are visible at the read port at the first sampling point after the clock edge that captures them. A change to run reaches the counter one edge later, so the bench waits an extra cycle before it checks that the counter is zero. The counter step is measured as the exact number of cycles between two consecutive observed changes of the counter, for all eight select values. This removes any dependence on where the free-running prescaler happened to be when counting started. `rst_req` is sampled on every falling edge from its first high sample until it drops, and the number of high samples is compared with `RST_CYCLES`.

// File: rtl/pwdt_pkg.sv
package pwdt_pkg;

    localparam logic [7:0] KEY_CTRL = 8'hA5;
    localparam logic [7:0] KEY_CNT  = 8'h5A;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_RST  = 2'd2;

    typedef struct packed {
        logic       ovf;
        logic       irq_en;
        logic       run;
        logic [1:0] rsv;
        logic [2:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic       hit;
        logic       rst_en;
        logic [5:0] rsv;
    } rctl_t;

    localparam ctrl_t CTRL_INIT = '{ovf: 1'b0, irq_en: 1'b0, run: 1'b0, rsv: 2'b11, sel: 3'd0};
    localparam rctl_t RCTL_INIT = '{hit: 1'b0, rst_en: 1'b0, rsv: 6'h3F};

    function automatic int unsigned tap_exp(input logic [2:0] sel);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 5;
            3'd2:    return 6;
            3'd3:    return 7;
            3'd4:    return 8;
            3'd5:    return 9;
            3'd6:    return 11;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/pwdt_prescaler.sv
module pwdt_prescaler
    import pwdt_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W:0]   mask;

    always_ff @(posedge clk) begin
        if (rst) pre <= '0;
        else     pre <= pre + 1'b1;
    end

    always_comb begin
        mask = ({{PRE_W{1'b0}}, 1'b1} << tap_exp(sel)) - {{PRE_W{1'b0}}, 1'b1};
        tick = (({1'b0, pre} & mask) == mask);
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

endmodule

// File: rtl/pwdt_counter.sv
module pwdt_counter (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] cnt,
    output logic       wrap
);
    assign wrap = run && tick && !load && (cnt == 8'hFF);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= 8'h00;
        else if (load)   cnt <= load_val;
        else if (tick)   cnt <= cnt + 8'd1;
    end

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst) !run |=> cnt == 8'h00);
    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load) |=> cnt == $past(cnt) + 8'd1);

endmodule

// File: rtl/pwdt_regs.sv
module pwdt_regs
    import pwdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  cnt,
    input  logic        wrap,
    output logic        run,
    output logic [2:0]  sel,
    output logic        cnt_load,
    output logic [7:0]  cnt_val,
    output logic        irq,
    output logic        rst_req
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    ctrl_t         ctrl;
    rctl_t         rctl;
    logic          ovf_arm, hit_arm;
    logic [RW-1:0] rcnt;
    logic          wr_ctrl, wr_rst, clr_ovf, clr_hit;

    always_comb begin
        wr_ctrl  = bus_wr && bus_word && (bus_addr == ADDR_CTRL) && (bus_wdata[15:8] == KEY_CTRL);
        cnt_load = bus_wr && bus_word && (bus_addr == ADDR_CTRL) && (bus_wdata[15:8] == KEY_CNT);
        wr_rst   = bus_wr && !bus_word && (bus_addr == ADDR_RST);
        clr_ovf  = wr_ctrl && !bus_wdata[7];
        clr_hit  = wr_rst && !bus_wdata[7];
        cnt_val  = bus_wdata[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CTRL_INIT;
            rctl    <= RCTL_INIT;
            ovf_arm <= 1'b0;
            hit_arm <= 1'b0;
            rcnt    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.irq_en <= bus_wdata[6];
                ctrl.run    <= bus_wdata[5];
                ctrl.sel    <= bus_wdata[2:0];
            end
            if (wrap)                    ctrl.ovf <= 1'b1;
            else if (clr_ovf && ovf_arm) ctrl.ovf <= 1'b0;

            if (clr_ovf)                                         ovf_arm <= 1'b0;
            else if (bus_rd && bus_addr == ADDR_CTRL && ctrl.ovf) ovf_arm <= 1'b1;

            if (wr_rst) rctl.rst_en <= bus_wdata[6];
            if (wrap && rctl.rst_en)     rctl.hit <= 1'b1;
            else if (clr_hit && hit_arm) rctl.hit <= 1'b0;

            if (clr_hit)                                        hit_arm <= 1'b0;
            else if (bus_rd && bus_addr == ADDR_RST && rctl.hit) hit_arm <= 1'b1;

            if (wrap && rctl.rst_en) rcnt <= RW'(RST_CYCLES);
            else if (rcnt != '0)     rcnt <= rcnt - 1'b1;
        end
    end

    always_comb begin
        run     = ctrl.run;
        sel     = ctrl.sel;
        irq     = ctrl.ovf && ctrl.irq_en && !rctl.rst_en;
        rst_req = (rcnt != '0);
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_CNT:  bus_rdata = cnt;
            ADDR_RST:  bus_rdata = rctl;
            default:   bus_rdata = 8'hFF;
        endcase
    end

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst) wrap |=> ctrl.ovf);
    // R6
    no_blind_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.ovf && !ovf_arm) |=> ctrl.ovf);
    // R2
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word && bus_wdata[15:8] != KEY_CTRL && !wrap) |=> $stable(ctrl));
    // R7
    rsv_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_CTRL) |-> bus_rdata[4:3] == 2'b11);
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst) irq |-> !rctl.rst_en);
    // R9
    rst_req_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && rctl.rst_en) |=> (rst_req && rctl.hit));

endmodule

// File: rtl/pwdt_top.sv
module pwdt_top
    import pwdt_pkg::*;
#(
    parameter int PRE_W      = 12,
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic        rst_req
);
    logic       tick, run, wrap, cnt_load;
    logic [2:0] sel;
    logic [7:0] cnt, cnt_val;

    pwdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .sel(sel), .tick(tick)
    );

    pwdt_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .load(cnt_load),
        .load_val(cnt_val), .cnt(cnt), .wrap(wrap)
    );

    pwdt_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .wrap(wrap), .run(run), .sel(sel), .cnt_load(cnt_load),
        .cnt_val(cnt_val), .irq(irq), .rst_req(rst_req)
    );

endmodule

// File: tb/sim_pwdt_top.sv
module sim_pwdt_top;
    localparam int RSTN = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        irq, rst_req;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwdt_top #(.PRE_W(12), .RST_CYCLES(RSTN)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr_word(input logic [7:0] key, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 2'd0; bus_wr = 1'b1; bus_word = 1'b1; bus_wdata = {key, d};
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b0;
    endtask

    task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_word = 1'b0; bus_wdata = {8'h00, d};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        int n;
        int unsigned divs[8] = '{2, 32, 64, 128, 256, 512, 2048, 4096};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(2'd0, v); check("R1 ctrl", v, 8'h18);
        peek(2'd1, v); check("R1 cnt", v, 8'h00);
        peek(2'd2, v); check("R1 rctl", v, 8'h3F);
        check("R1 irq", irq, 0);
        check("R1 rst_req", rst_req, 0);

        // R2 byte write and wrong key ignored
        wr_byte(2'd0, 8'h27); peek(2'd0, v); check("R2 byte write ignored", v, 8'h18);
        wr_word(8'h3C, 8'h27); peek(2'd0, v); check("R2 bad key ignored", v, 8'h18);
        wr_word(8'hA5, 8'h27); peek(2'd0, v); check("R2 keyed ctrl write", v, 8'h3F);
        // R7 reserved ones
        wr_word(8'hA5, 8'h00); peek(2'd0, v); check("R7 ctrl reserved", v, 8'h18);
        wr_byte(2'd2, 8'h00); peek(2'd2, v); check("R7 rctl reserved", v, 8'h3F);
        // R3 counter held while stopped
        wr_word(8'h5A, 8'h44); @(negedge clk); peek(2'd1, v); check("R3 held at zero", v, 8'h00);
        // R2 counter load while running
        wr_word(8'hA5, 8'h27);
        wr_word(8'h5A, 8'h40); peek(2'd1, v);
        check("R2 keyed cnt write", (v == 8'h40 || v == 8'h41) ? 1 : 0, 1);
        wr_word(8'h3C, 8'h99); peek(2'd1, v);
        check("R2 cnt bad key", (v >= 8'h40 && v <= 8'h42) ? 1 : 0, 1);
        // R3 clearing run zeroes the counter
        wr_word(8'hA5, 8'h07); @(negedge clk); peek(2'd1, v); check("R3 stop clears", v, 8'h00);

        // R4 / R5 sweep all selects
        for (int s = 0; s < 8; s++) begin
            wr_word(8'hA5, 8'h20 | 8'(s));
            wr_word(8'h5A, 8'hFD);
            n = 0;
            peek(2'd1, v);
            while (v != 8'hFE && n < 5000) begin @(negedge clk); peek(2'd1, v); n++; end
            n = 0;
            do begin @(negedge clk); peek(2'd1, v); n++; end while (v != 8'hFF && n < 5000);
            check($sformatf("R4 step sel %0d", s), n, int'(divs[s]));
            n = 0;
            do begin @(negedge clk); peek(2'd1, v); n++; end while (v != 8'h00 && n < 5000);
            check($sformatf("R4 wrap step sel %0d", s), n, int'(divs[s]));
            peek(2'd0, v); check($sformatf("R5 flag sel %0d", s), v[7], 1);
            rd(2'd0, v);
            wr_word(8'hA5, 8'h00);
            peek(2'd0, v); check($sformatf("R6 cleared sel %0d", s), v, 8'h18);
        end

        // R6 / R8 flag clear protocol
        wr_word(8'hA5, 8'h60);
        wr_word(8'h5A, 8'hF0);
        n = 0; peek(2'd0, v);
        while (!v[7] && n < 200) begin @(negedge clk); peek(2'd0, v); n++; end
        check("R8 irq on overflow", irq, 1);
        wr_word(8'hA5, 8'h40); peek(2'd0, v); check("R6 clear without read", v[7], 1);
        rd(2'd0, v);
        wr_word(8'hA5, 8'hC0); peek(2'd0, v); check("R6 write one no effect", v[7], 1);
        rd(2'd0, v);
        wr_word(8'hA5, 8'h40); peek(2'd0, v); check("R6 clear after read", v[7], 0);
        check("R8 irq drops", irq, 0);

        // R9 / R10 reset request
        wr_byte(2'd2, 8'h40); peek(2'd2, v); check("R10 rctl enable", v, 8'h7F);
        wr_word(8'hA5, 8'h60);
        wr_word(8'h5A, 8'hF8);
        n = 0;
        while (!rst_req && n < 200) begin @(negedge clk); n++; end
        check("R8 irq masked in reset mode", irq, 0);
        n = 0;
        while (rst_req && n < 100) begin n++; @(negedge clk); end
        check("R9 rst_req length", n, RSTN);
        peek(2'd2, v); check("R9 rctl flag", v, 8'hFF);
        wr_byte(2'd2, 8'h40); peek(2'd2, v); check("R6 rctl clear without read", v, 8'hFF);
        rd(2'd2, v);
        wr_byte(2'd2, 8'h00); peek(2'd2, v); check("R10 rctl clear", v, 8'h3F);
        wr_word(8'hA5, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule